// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operands of a vector or scalar load/store instruction into the address presented to an 8 KiB banked data store, the new value of the address register, and a pair of condition flags. Each accepted request takes an address register, a second register, an unsigned immediate, a two-bit addressing mode and a raw-access marker. One clock later it presents the access address with the register's stride selector, an optional register write-back, and the carry/zero flags.

The two post-increment modes access memory at the register's own address and write back the register advanced by the second operand. The immediate mode without post-increment forms its address by a bitwise OR of register and immediate, yet sets its flags from their arithmetic sum, and writes nothing back. Raw accesses always use register-plus-register post-increment, produce no flags and tell the memory to ignore the stride selector.

Top module: `agu_ls`

## Requirements
- R1: Mode code 0 (register plus register, post-increment): the access address equals areg_i bits AW-1..0, the write-back low AW bits equal (areg_i + breg_i) modulo 2^AW, and wb_en_o is 1.
- R2: Mode code 1 (register plus immediate, post-increment): the access address equals areg_i bits AW-1..0, the write-back low AW bits equal (areg_i + zero-extended imm_i) modulo 2^AW, and wb_en_o is 1.
- R3: Mode code 2 (register with immediate, no post-increment): the access address equals areg_i bits AW-1..0 ORed with the zero-extended imm_i.
- R4: In mode code 2, wb_en_o is 0, wb_val_o carries areg_i unchanged, and the flags come from the arithmetic sum areg_i + zero-extended imm_i, not from the ORed address.
- R5: For every non-raw valid access flag_en_o is 1, flag_carry_o is the carry out of the AW-bit addition and flag_zero_o is 1 exactly when the AW-bit sum is zero.
- R6: acc_stride_o equals the top SW bits of areg_i (bits 31..30 by default) and acc_raw_o equals req_raw_i, for every valid access.
- R7: On a post-increment write-back, wb_val_o bits DW-1..AW equal those of areg_i, stride field included.
- R8: With req_raw_i set, the mode input is ignored and register plus register post-increment addressing is used, with flag_en_o at 0.
- R9: Mode code 3 is reserved: a request with it, or any cycle with req_valid_i at 0, yields acc_valid_o, wb_en_o and flag_en_o all 0.
- R10: Results appear exactly one clock after the request is sampled; reset clears acc_valid_o, wb_en_o and flag_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_mode_i | input | 2 | Addressing mode: 0 reg+reg post-inc, 1 reg+imm post-inc, 2 reg OR imm, 3 reserved |
| req_raw_i | input | 1 | Raw access (stride ignored by memory, no flags) |
| areg_i | input | DW | Address register value, stride selector in top SW bits |
| breg_i | input | DW | Second register value (increment in mode 0) |
| imm_i | input | IMW | Unsigned immediate |
| acc_valid_o | output | 1 | Access outputs valid |
| acc_addr_o | output | AW | Byte address into the data store |
| acc_stride_o | output | SW | Stride selector for the memory's bank mapping |
| acc_raw_o | output | 1 | Raw access marker |
| wb_en_o | output | 1 | Address register write-back enable |
| wb_val_o | output | DW | Address register write-back value |
| flag_en_o | output | 1 | Flag write enable |
| flag_carry_o | output | 1 | Carry out of the AW-bit sum |
| flag_zero_o | output | 1 | AW-bit sum is zero |

## Verification
The bench builds the unit with a 6-bit address space and a 4-bit immediate, keeping the 32-bit register and 2-bit stride field. That shrinks the arithmetic enough to sweep every pair of low address and second-register bits for mode 0 and every address/immediate pair for the immediate modes, so every carry-out and zero-sum case and every OR-versus-add divergence is reached. Upper register bits and stride selectors are varied by a multiplicative hash so preservation on write-back is seen across many patterns.

// File: rtl/agu_ls_pkg.sv
package agu_ls_pkg;

    typedef enum logic [1:0] {
        MODE_RR_POST = 2'd0,
        MODE_RI_POST = 2'd1,
        MODE_RI_OR   = 2'd2,
        MODE_RSVD    = 2'd3
    } agu_mode_e;

endpackage

// File: rtl/agu_ls_opsel.sv
module agu_ls_opsel
    import agu_ls_pkg::*;
#(
    parameter int AW  = 13,
    parameter int IMW = 11
) (
    input  agu_mode_e         mode_i,
    input  logic [AW-1:0]     areg_lo_i,
    input  logic [AW-1:0]     breg_lo_i,
    input  logic [IMW-1:0]    imm_i,
    output logic [AW-1:0]     opnd_o,
    output logic [AW-1:0]     or_addr_o
);

    logic [AW-1:0] imm_ext;

    assign imm_ext   = AW'(imm_i);
    assign opnd_o    = (mode_i == MODE_RR_POST) ? breg_lo_i : imm_ext;
    assign or_addr_o = areg_lo_i | imm_ext;

endmodule

// File: rtl/agu_ls_sum.sv
module agu_ls_sum #(
    parameter int AW = 13
) (
    input  logic [AW-1:0] a_i,
    input  logic [AW-1:0] b_i,
    output logic [AW-1:0] sum_o,
    output logic          carry_o,
    output logic          zero_o
);

    logic [AW:0] full;

    assign full    = {1'b0, a_i} + {1'b0, b_i};
    assign sum_o   = full[AW-1:0];
    assign carry_o = full[AW];
    assign zero_o  = (full[AW-1:0] == '0);

endmodule

// File: rtl/agu_ls.sv
module agu_ls
    import agu_ls_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 13,
    parameter int IMW = 11,
    parameter int SW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid_i,
    input  logic [1:0]     req_mode_i,
    input  logic           req_raw_i,
    input  logic [DW-1:0]  areg_i,
    input  logic [DW-1:0]  breg_i,
    input  logic [IMW-1:0] imm_i,
    output logic           acc_valid_o,
    output logic [AW-1:0]  acc_addr_o,
    output logic [SW-1:0]  acc_stride_o,
    output logic           acc_raw_o,
    output logic           wb_en_o,
    output logic [DW-1:0]  wb_val_o,
    output logic           flag_en_o,
    output logic           flag_carry_o,
    output logic           flag_zero_o
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [SW-1:0] stride;
        logic          raw;
        logic          wb_en;
        logic [DW-1:0] wb_val;
        logic          flg_en;
        logic          carry;
        logic          zero;
    } res_t;

    res_t          res_d, res_q;
    agu_mode_e     mode_eff;
    logic [AW-1:0] opnd, or_addr, sum;
    logic          carry, zero;
    logic          unused_breg_hi;

    assign unused_breg_hi = ^breg_i[DW-1:AW];

    // raw accesses always use register plus register post-increment
    assign mode_eff = req_raw_i ? MODE_RR_POST : agu_mode_e'(req_mode_i);

    agu_ls_opsel #(.AW(AW), .IMW(IMW)) u_opsel (
        .mode_i    (mode_eff),
        .areg_lo_i (areg_i[AW-1:0]),
        .breg_lo_i (breg_i[AW-1:0]),
        .imm_i     (imm_i),
        .opnd_o    (opnd),
        .or_addr_o (or_addr)
    );

    agu_ls_sum #(.AW(AW)) u_sum (
        .a_i     (areg_i[AW-1:0]),
        .b_i     (opnd),
        .sum_o   (sum),
        .carry_o (carry),
        .zero_o  (zero)
    );

    always_comb begin
        res_d = '0;
        if (req_valid_i && mode_eff != MODE_RSVD) begin
            res_d.vld    = 1'b1;
            res_d.stride = areg_i[DW-1 -: SW];
            res_d.raw    = req_raw_i;
            res_d.flg_en = !req_raw_i;
            res_d.carry  = !req_raw_i && carry;
            res_d.zero   = !req_raw_i && zero;
            case (mode_eff)
                MODE_RI_OR: begin
                    res_d.addr   = or_addr;
                    res_d.wb_en  = 1'b0;
                    res_d.wb_val = areg_i;
                end
                default: begin
                    res_d.addr   = areg_i[AW-1:0];
                    res_d.wb_en  = 1'b1;
                    res_d.wb_val = {areg_i[DW-1:AW], sum};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc_valid_o  = res_q.vld;
    assign acc_addr_o   = res_q.addr;
    assign acc_stride_o = res_q.stride;
    assign acc_raw_o    = res_q.raw;
    assign wb_en_o      = res_q.wb_en;
    assign wb_val_o     = res_q.wb_val;
    assign flag_en_o    = res_q.flg_en;
    assign flag_carry_o = res_q.carry;
    assign flag_zero_o  = res_q.zero;

endmodule

// File: rtl/agu_ls_chk.sv
module agu_ls_chk #(
    parameter int DW  = 32,
    parameter int AW  = 13,
    parameter int IMW = 11,
    parameter int SW  = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid_i,
    input logic [1:0]     req_mode_i,
    input logic           req_raw_i,
    input logic [DW-1:0]  areg_i,
    input logic [DW-1:0]  breg_i,
    input logic [IMW-1:0] imm_i,
    input logic           acc_valid_o,
    input logic [AW-1:0]  acc_addr_o,
    input logic [SW-1:0]  acc_stride_o,
    input logic           acc_raw_o,
    input logic           wb_en_o,
    input logic [DW-1:0]  wb_val_o,
    input logic           flag_en_o,
    input logic           flag_carry_o,
    input logic           flag_zero_o
);

    logic unused_chk;
    assign unused_chk = ^{breg_i[DW-1:AW], flag_carry_o, flag_zero_o};

    // R1
    rr_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_raw_i || req_mode_i == 2'd0)) |=>
        (acc_addr_o == $past(areg_i[AW-1:0])) && wb_en_o &&
        (wb_val_o[AW-1:0] == AW'($past(areg_i[AW-1:0]) + $past(breg_i[AW-1:0]))));

    // R3
    or_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_raw_i && req_mode_i == 2'd2) |=>
        acc_addr_o == ($past(areg_i[AW-1:0]) | AW'($past(imm_i))));

    // R4
    or_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_raw_i && req_mode_i == 2'd2) |=> acc_valid_o && !wb_en_o);

    // R6
    stride_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_raw_i || req_mode_i != 2'd3)) |=>
        (acc_stride_o == $past(areg_i[DW-1 -: SW])) && (acc_raw_o == $past(req_raw_i)));

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> wb_val_o[DW-1:AW] == $past(areg_i[DW-1:AW]));

    // R8
    raw_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_raw_i) |=> acc_raw_o && !flag_en_o && wb_en_o);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid_i || (!req_raw_i && req_mode_i == 2'd3)) |=>
        !acc_valid_o && !wb_en_o && !flag_en_o);

    // R10
    enables_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o || flag_en_o) |-> acc_valid_o);

endmodule

bind agu_ls agu_ls_chk #(.DW(DW), .AW(AW), .IMW(IMW), .SW(SW)) u_chk (.*);

// File: tb/agu_ls_test.sv
module agu_ls_test;

    localparam int DW  = 32;
    localparam int AW  = 6;
    localparam int IMW = 4;
    localparam int SW  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid_i;
    logic [1:0]     req_mode_i;
    logic           req_raw_i;
    logic [DW-1:0]  areg_i, breg_i;
    logic [IMW-1:0] imm_i;
    logic           acc_valid_o, acc_raw_o, wb_en_o, flag_en_o, flag_carry_o, flag_zero_o;
    logic [AW-1:0]  acc_addr_o;
    logic [SW-1:0]  acc_stride_o;
    logic [DW-1:0]  wb_val_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    agu_ls #(.DW(DW), .AW(AW), .IMW(IMW), .SW(SW)) uut (.*);

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] mix(input int i, input int s);
        return (i * 32'h9E3779B1) ^ (s * 32'h85EBCA6B);
    endfunction

    task automatic run(input logic v, input logic [1:0] m, input logic r,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [IMW-1:0] im);
        logic [1:0]    eff;
        logic [AW-1:0] op, ea;
        logic [AW:0]   s;
        string         t;
        req_valid_i = v; req_mode_i = m; req_raw_i = r;
        areg_i = a; breg_i = b; imm_i = im;
        @(posedge clk);
        @(negedge clk);
        eff = r ? 2'd0 : m;
        op  = (eff == 2'd0) ? b[AW-1:0] : {{(AW-IMW){1'b0}}, im};
        s   = {1'b0, a[AW-1:0]} + {1'b0, op};
        if (!v || eff == 2'd3) begin
            chk("R9", {acc_valid_o, wb_en_o, flag_en_o}, 3'b000);
        end else begin
            t = r ? "R8" : (eff == 2'd0) ? "R1" : (eff == 2'd1) ? "R2" : "R3";
            ea = (eff == 2'd2) ? (a[AW-1:0] | {{(AW-IMW){1'b0}}, im}) : a[AW-1:0];
            chk("R10", acc_valid_o, 1'b1);
            chk(t, acc_addr_o, ea);
            chk(eff == 2'd2 ? "R4" : t, wb_en_o, eff != 2'd2);
            if (eff == 2'd2) begin
                chk("R4", wb_val_o, a);
            end else begin
                chk(t, wb_val_o[AW-1:0], s[AW-1:0]);
                chk("R7", wb_val_o[DW-1:AW], a[DW-1:AW]);
            end
            if (r) chk("R8", flag_en_o, 1'b0);
            else   chk(eff == 2'd2 ? "R4" : "R5", {flag_en_o, flag_carry_o, flag_zero_o},
                       {1'b1, s[AW], s[AW-1:0] == '0});
            chk("R6", {acc_stride_o, acc_raw_o}, {a[DW-1 -: SW], r});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid_i = 1'b1; req_mode_i = 2'd0; req_raw_i = 1'b0;
        areg_i = '0; breg_i = '0; imm_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset clears all enables even with a request at the inputs
        chk("R10", {acc_valid_o, wb_en_o, flag_en_o}, 3'b000);
        rst_n = 1'b1;
        req_valid_i = 1'b0;
        @(negedge clk);

        // R1, R5, R7: every low address / second register pair
        for (int ai = 0; ai < (1 << AW); ai++)
            for (int bi = 0; bi < (1 << AW); bi++)
                run(1'b1, 2'd0, 1'b0, {mix(ai, bi) >> AW, AW'(ai)},
                    {mix(bi, ai) >> AW, AW'(bi)}, '0);

        // R2, R3, R4: every low address / immediate pair
        for (int md = 1; md <= 2; md++)
            for (int ai = 0; ai < (1 << AW); ai++)
                for (int ii = 0; ii < (1 << IMW); ii++)
                    run(1'b1, 2'(md), 1'b0, {mix(ai, ii + md) >> AW, AW'(ai)},
                        mix(ii, ai), IMW'(ii));

        // R8: raw override whatever the mode field holds
        for (int ai = 0; ai < (1 << AW); ai++)
            for (int k = 0; k < 8; k++)
                run(1'b1, 2'(k), 1'b1, {mix(ai, k) >> AW, AW'(ai)},
                    mix(k, ai), IMW'(k + ai));

        // R9: reserved mode and idle cycles
        for (int k = 0; k < 32; k++) begin
            run(1'b1, 2'd3, 1'b0, mix(k, 7), mix(k, 9), IMW'(k));
            run(1'b0, 2'(k), 1'b0, mix(k, 3), mix(k, 5), IMW'(k));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule